// File: doc/BRIEF.md
# SYSREF-Aligned Local Multiframe Counter with Sync Request Control

This block keeps the local multiframe count for a serial data-converter link receiver, running on the link clock. The count climbs from 0 to `MF_LEN-1` and then wraps to 0. Each wrap is a multiframe boundary, and the block flags it with a one-cycle strobe. An external SYSREF pulse sets the phase of the count. The block samples SYSREF in a register on the link clock and acts only on a low-to-high transition. After a fixed latency of two link clocks from that sample, it forces the count to zero. A SYSREF pulse that lands in phase with the running count produces no visible jump.

The block also drives the active-low sync request (SYNC_N) towards the transmitter. A small state machine controls it:

- **WAIT_SYNC** holds the request low until the receiver reports code-group sync through `cgs_locked`. The transition **lock_seen** then moves the machine to WAIT_BOUNDARY.
- **WAIT_BOUNDARY** waits for the next multiframe boundary. The transition **boundary_hit** then moves the machine to RELEASED, which deasserts the request in the cycle right after the boundary.
- **lock_lost** returns the machine to WAIT_SYNC whenever `cgs_locked` falls, from either WAIT_BOUNDARY or RELEASED.

Top module: `lmfc_align_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mf_count` is `MF_LEN-1`, `mf_boundary` is 0 and `sync_req_n` is 0.
- R2: Without a SYSREF rising edge, `mf_count` rises by one each link clock and wraps from `MF_LEN-1` to 0.
- R3: `mf_boundary` is 1 in exactly those cycles where `mf_count` is 0.
- R4: Suppose `sysref_in` is sampled high at clock edge k and was sampled low at edge k-1. Then `mf_count` is 0 after edge k+2, whatever its phase was before, and it counts up from there.
- R5: Only the rising edge of SYSREF acts. Holding `sysref_in` high has no further effect on the count. A pulse whose realignment falls exactly on the wrap to 0 leaves the count sequence unchanged.
- R6: `sync_req_n` stays 0 until `cgs_locked` has been seen high. It then goes to 1 in the cycle after the next cycle where `mf_count` is 0, so it becomes visible together with count 1.
- R7: If `cgs_locked` is sampled low, `sync_req_n` is 0 after that edge. A later release again waits for a fresh boundary, as in R6.
- R8: If `cgs_locked` is first sampled high while `mf_count` already shows 0, that boundary does not release the request. The release waits for the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_in | input | 1 | SYSREF level, already synchronous to the link clock |
| cgs_locked | input | 1 | Receiver reports code-group sync achieved |
| mf_count | output | $clog2(MF_LEN) | Local multiframe count |
| mf_boundary | output | 1 | One-cycle strobe while the count is 0 |
| sync_req_n | output | 1 | Active-low sync request towards the transmitter |

## Verification
A wrong phase in the counter shows up on `mf_count` within one multiframe. It is visible on the third edge after a SYSREF sample, where the count must read 0, and on every later wrap. A sampling register or delay stage that is off by one moves that zero by one cycle, which is visible right away. A sync state machine that skips or misreads a state releases `sync_req_n` one multiframe early or on a non-boundary count, so the mismatch appears within `MF_LEN` cycles of lock.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_SYNC     = 2'd0,
        ST_WAIT_BOUNDARY = 2'd1,
        ST_RELEASED      = 2'd2
    } sync_state_e;
endpackage

// File: rtl/lmfc_sysref_det.sv
module lmfc_sysref_det #(
    parameter int ALIGN_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_in,
    output logic realign
);
    localparam int PIPE_LEN = (ALIGN_LAT > 1) ? ALIGN_LAT - 1 : 1;

    logic                sample_q;
    logic                sample_prev;
    logic                rise;
    logic [PIPE_LEN-1:0] pipe_q;

    assign rise = sample_q & ~sample_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q    <= 1'b0;
            sample_prev <= 1'b0;
            pipe_q      <= '0;
        end else begin
            sample_q    <= sysref_in;
            sample_prev <= sample_q;
            if (PIPE_LEN == 1) pipe_q <= rise;
            else               pipe_q <= {pipe_q[PIPE_LEN-2:0], rise};
        end
    end

    assign realign = pipe_q[PIPE_LEN-1];

    // A level held high must not realign twice in a row (R5)
    assert_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_q && sample_prev) |=> !pipe_q[0]);
endmodule

// File: rtl/lmfc_counter.sv
module lmfc_counter #(
    parameter int MF_LEN = 8,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign,
    output logic [CNT_W-1:0] count,
    output logic             boundary
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        if (realign)            count_nxt = '0;
        else if (count == LAST) count_nxt = '0;
        else                    count_nxt = count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= LAST;
            boundary <= 1'b0;
        end else begin
            count    <= count_nxt;
            boundary <= (count_nxt == '0);
        end
    end

    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign && count == LAST) |=> count == '0);
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> count == '0);
endmodule

// File: rtl/lmfc_sync_fsm.sv
module lmfc_sync_fsm
    import lmfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cgs_locked,
    input  logic boundary,
    output logic sync_req_n
);
    sync_state_e state_q;
    sync_state_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_SYNC;
        else        state_q <= state_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_WAIT_SYNC:     if (cgs_locked) state_nxt = ST_WAIT_BOUNDARY;      // lock_seen
            ST_WAIT_BOUNDARY: if (!cgs_locked) state_nxt = ST_WAIT_SYNC;        // lock_lost
                              else if (boundary) state_nxt = ST_RELEASED;      // boundary_hit
            ST_RELEASED:      if (!cgs_locked) state_nxt = ST_WAIT_SYNC;        // lock_lost
            default:          state_nxt = ST_WAIT_SYNC;
        endcase
    end

    always_comb begin
        sync_req_n = (state_q == ST_RELEASED);
    end

    assert_release_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_req_n) |-> $past(boundary));
    assert_drop_on_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cgs_locked |=> !sync_req_n);
endmodule

// File: rtl/lmfc_align_gen.sv
module lmfc_align_gen #(
    parameter int MF_LEN = 8,
    localparam int CNT_W = (MF_LEN > 1) ? $clog2(MF_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sysref_in,
    input  logic             cgs_locked,
    output logic [CNT_W-1:0] mf_count,
    output logic             mf_boundary,
    output logic             sync_req_n
);
    localparam int ALIGN_LAT = 2;

    logic realign;

    lmfc_sysref_det #(.ALIGN_LAT(ALIGN_LAT)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysref_in (sysref_in),
        .realign   (realign)
    );

    lmfc_counter #(.MF_LEN(MF_LEN), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .realign  (realign),
        .count    (mf_count),
        .boundary (mf_boundary)
    );

    lmfc_sync_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cgs_locked (cgs_locked),
        .boundary   (mf_boundary),
        .sync_req_n (sync_req_n)
    );

    assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mf_boundary == (mf_count == '0));
    assert_no_release_midframe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_req_n) |-> mf_count == CNT_W'(1 % MF_LEN));
endmodule

// File: tb/lmfc_align_gen_test.sv
module lmfc_align_gen_test;
    localparam int PERIOD = 10;
    localparam int NVEC = 31;
    // {sysref, locked, count[2:0], boundary, sync_req_n}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_0_000_1_0, 7'b0_0_001_0_0, 7'b0_0_010_0_0, 7'b1_0_011_0_0,
        7'b0_0_100_0_0, 7'b0_0_000_1_0, 7'b0_0_001_0_0, 7'b0_0_010_0_0,
        7'b0_0_011_0_0, 7'b0_0_100_0_0, 7'b0_0_101_0_0, 7'b1_0_110_0_0,
        7'b1_0_111_0_0, 7'b1_0_000_1_0, 7'b1_0_001_0_0, 7'b1_0_010_0_0,
        7'b0_0_011_0_0, 7'b0_1_100_0_0, 7'b0_1_101_0_0, 7'b0_1_110_0_0,
        7'b0_1_111_0_0, 7'b0_1_000_1_0, 7'b0_1_001_0_1, 7'b0_1_010_0_1,
        7'b0_0_011_0_0, 7'b0_0_100_0_0, 7'b0_1_101_0_0, 7'b0_1_110_0_0,
        7'b0_1_111_0_0, 7'b0_1_000_1_0, 7'b0_1_001_0_1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sysref_in = 1'b0;
    logic       cgs_locked = 1'b0;
    logic [2:0] mf_count;
    logic       mf_boundary;
    logic       sync_req_n;
    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    lmfc_align_gen #(.MF_LEN(8)) uut (
        .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in), .cgs_locked(cgs_locked),
        .mf_count(mf_count), .mf_boundary(mf_boundary), .sync_req_n(sync_req_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(PERIOD * 100000);
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1 count", mf_count, 7);
        chk("R1 boundary", mf_boundary, 0);
        chk("R1 sync_req_n", sync_req_n, 0);
        rst_n = 1'b1;

        // Vector walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            sysref_in  = VEC[i][6];
            cgs_locked = VEC[i][5];
            tick();
            chk($sformatf("R2 R4 R5 count v%0d", i), mf_count, VEC[i][4:2]);
            chk($sformatf("R3 boundary v%0d", i), mf_boundary, VEC[i][1]);
            chk($sformatf("R6 R7 sync_req_n v%0d", i), sync_req_n, VEC[i][0]);
        end

        // R2: long free run, several wraps
        sysref_in = 1'b0;
        for (int n = 1; n <= 20; n++) begin
            tick();
            chk("R2 free run", mf_count, (1 + n) % 8);
            chk("R3 free run", mf_boundary, ((1 + n) % 8) == 0);
        end

        // R1: reset in mid-operation
        rst_n = 1'b0;
        cgs_locked = 1'b0;
        tick();
        chk("R1 mid count", mf_count, 7);
        chk("R1 mid sync_req_n", sync_req_n, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 count after release", mf_count, 0);

        // R8: lock seen while count already 0
        cgs_locked = 1'b1;
        tick();
        chk("R8 count", mf_count, 1);
        chk("R8 held", sync_req_n, 0);
        for (int n = 2; n <= 8; n++) begin
            tick();
            chk("R8 still held", sync_req_n, 0);
        end
        chk("R8 boundary", mf_boundary, 1);
        tick();
        chk("R8 release", sync_req_n, 1);
        chk("R8 release count", mf_count, 1);

        // R4: realign from count 1
        sysref_in = 1'b1;
        tick();
        chk("R4 pre", mf_count, 2);
        sysref_in = 1'b0;
        tick();
        chk("R4 pre2", mf_count, 3);
        tick();
        chk("R4 realigned", mf_count, 0);
        tick();
        chk("R4 continue", mf_count, 1);
        chk("R7 unaffected", sync_req_n, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule